// File: doc/BRIEF.md
# Synchronous Answer-to-Reset Serializer

This block sends a fixed 32-bit identification word, one bit at a time, on a tri-state serial data pin when the card reader performs a synchronous reset. The host drives chip select low and raises the reset pin for a while. When the reset pin falls, the first bit appears. Each later falling edge of the serial clock brings out the next bit. The word is set by a parameter when the design is built. Nothing can change it while the design runs.

All pins reach the block from off-chip. The block samples them with a much faster system clock through two-flop synchronisers and then detects their edges. A busy flag from the nonvolatile write engine stops a response from starting while a write is in progress. Raising chip select at any point cancels the response and sends the block back to standby. The block drives a data value and a separate output enable for the pad.

Top module: `atr_shifter`

## Requirements
- R1: While the system reset is asserted, the output enable is low and the data output is 0.
- R2: A rising edge of the reset pin with chip select low and the busy flag low arms the block. When the reset pin then falls, the output enable goes high and the data output shows bit 0 of the pattern.
- R3: While streaming, each falling edge of the serial clock moves the data output to the next higher pattern bit, so bits come out least significant first. A rising edge of the serial clock leaves the output unchanged.
- R4: The falling serial clock edge after bit 31 is shown turns the output enable off. Later serial clock edges leave it off until a new reset pulse arrives.
- R5: A reset pulse that rises while the busy flag is high starts no response, and the output enable stays low.
- R6: A reset pulse that rises while chip select is high starts no response.
- R7: Chip select going high while the block is armed or streaming turns the output enable off. It stays off after chip select returns low, until a new reset pulse arrives.
- R8: The data output is 0 whenever the output enable is low.
- R9: A new reset pulse during a stream turns the output off while the reset pin is high. When the pin falls, the stream restarts from bit 0.
- R10: Serial clock edges that arrive between the rise and the fall of the reset pin do not advance the stream, so the first bit shown is always bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| csPin | input | 1 | Chip select pin, active low |
| rstPin | input | 1 | Synchronous-reset request pin, active high |
| sclPin | input | 1 | Serial clock pin |
| wrBusy | input | 1 | Nonvolatile write in progress, from the write engine |
| dataOut | output | 1 | Serial data value for the pad |
| dataOe | output | 1 | Pad output enable, high while a bit is presented |

## Verification
The hardest case to reach from the pins is a deselect that lands at an arbitrary bit position in the middle of a stream. The check must then show that chip select going low again does not resume the stream. The bench draws the abort position and the serial clock high and low times at random from a fixed seed, and it checks every bit up to the abort. Directed cases cover serial clock edges in the armed window, reset pulses during busy or while deselected, and a restart in the middle of a stream.

// File: rtl/atr_pkg.sv
package atr_pkg;
  // Bit positions of the pins inside the synchroniser vector
  localparam int PIN_CS  = 0;
  localparam int PIN_RST = 1;
  localparam int PIN_SCL = 2;
  localparam int PIN_CNT = 3;

  typedef struct packed {
    logic load;   // take the pattern and enable the pad
    logic shift;  // advance to the next bit
    logic stop;   // release the pad
  } atrStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_STREAM = 2'd2
  } atrState_t;
endpackage

// File: rtl/atr_sync.sv
module atr_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] levelOut,
  output logic [WIDTH-1:0] riseOut,
  output logic [WIDTH-1:0] fallOut
);
  logic [WIDTH-1:0] chain [STAGES];
  logic [WIDTH-1:0] prevLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= RESET_VAL;
    else       chain[0] <= pinIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= RESET_VAL;
      else       chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= RESET_VAL;
    else       prevLevel <= chain[STAGES-1];
  end

  assign levelOut = chain[STAGES-1];
  assign riseOut  = chain[STAGES-1] & ~prevLevel;
  assign fallOut  = ~chain[STAGES-1] & prevLevel;
endmodule

// File: rtl/atr_ctrl.sv
module atr_ctrl
  import atr_pkg::*;
#(
  parameter int ATR_BITS = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csLevel,
  input  logic       rstRise,
  input  logic       rstFall,
  input  logic       sclFall,
  input  logic       wrBusy,
  output atrStrobe_t strobe
);
  localparam int CNT_W = $clog2(ATR_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ATR_BITS);

  atrState_t state, stateNxt;
  logic [CNT_W-1:0] bitCnt, bitCntNxt;

  always_comb begin
    stateNxt  = state;
    bitCntNxt = bitCnt;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (rstRise && !csLevel && !wrBusy) stateNxt = ST_ARMED;
      end
      ST_ARMED: begin
        if (csLevel) begin
          stateNxt = ST_IDLE;
        end else if (rstFall) begin
          strobe.load = 1'b1;
          bitCntNxt   = CNT_W'(1);
          stateNxt    = ST_STREAM;
        end
      end
      ST_STREAM: begin
        if (csLevel) begin
          strobe.stop = 1'b1;
          stateNxt    = ST_IDLE;
        end else if (rstRise) begin
          strobe.stop = 1'b1;
          stateNxt    = wrBusy ? ST_IDLE : ST_ARMED;
        end else if (sclFall) begin
          if (bitCnt == LAST_CNT) begin
            strobe.stop = 1'b1;
            stateNxt    = ST_IDLE;
          end else begin
            strobe.shift = 1'b1;
            bitCntNxt    = bitCnt + CNT_W'(1);
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= stateNxt;
      bitCnt <= bitCntNxt;
    end
  end
endmodule

// File: rtl/atr_datapath.sv
module atr_datapath
  import atr_pkg::*;
#(
  parameter int ATR_BITS = 32,
  parameter logic [ATR_BITS-1:0] ATR_PATTERN = '0
) (
  input  logic       clk,
  input  logic       rstN,
  input  atrStrobe_t strobe,
  output logic       dataOut,
  output logic       dataOe
);
  logic [ATR_BITS-1:0] shReg;
  logic oeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      oeReg <= 1'b0;
    end else if (strobe.load) begin
      shReg <= ATR_PATTERN;
      oeReg <= 1'b1;
    end else if (strobe.stop) begin
      oeReg <= 1'b0;
    end else if (strobe.shift) begin
      shReg <= {1'b0, shReg[ATR_BITS-1:1]};
    end
  end

  assign dataOut = oeReg & shReg[0];
  assign dataOe  = oeReg;
endmodule

// File: rtl/atr_shifter.sv
module atr_shifter
  import atr_pkg::*;
#(
  parameter int ATR_BITS = 32,
  parameter logic [ATR_BITS-1:0] ATR_PATTERN = 32'h3B8A_52C9,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csPin,
  input  logic rstPin,
  input  logic sclPin,
  input  logic wrBusy,
  output logic dataOut,
  output logic dataOe
);
  localparam logic [PIN_CNT-1:0] PIN_IDLE = PIN_CNT'(1 << PIN_CS);

  logic [PIN_CNT-1:0] pinLevel, pinRise, pinFall;
  logic csLvl, rstRiseEv, rstFallEv, sclFallEv;
  atrStrobe_t strobe;

  atr_sync #(
    .STAGES(SYNC_STAGES),
    .WIDTH(PIN_CNT),
    .RESET_VAL(PIN_IDLE)
  ) u_sync (
    .clk(clk),
    .rstN(rstN),
    .pinIn({sclPin, rstPin, csPin}),
    .levelOut(pinLevel),
    .riseOut(pinRise),
    .fallOut(pinFall)
  );

  assign csLvl     = pinLevel[PIN_CS];
  assign rstRiseEv = pinRise[PIN_RST];
  assign rstFallEv = pinFall[PIN_RST];
  assign sclFallEv = pinFall[PIN_SCL];

  atr_ctrl #(.ATR_BITS(ATR_BITS)) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .csLevel(csLvl),
    .rstRise(rstRiseEv),
    .rstFall(rstFallEv),
    .sclFall(sclFallEv),
    .wrBusy(wrBusy),
    .strobe(strobe)
  );

  atr_datapath #(.ATR_BITS(ATR_BITS), .ATR_PATTERN(ATR_PATTERN)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .dataOut(dataOut),
    .dataOe(dataOe)
  );
endmodule

// File: rtl/atr_shifter_chk.sv
module atr_shifter_chk (
  input logic clk,
  input logic rstN,
  input logic dataOut,
  input logic dataOe,
  input logic csLevel,
  input logic rstFall,
  input logic sclFall
);
  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (!dataOe && !dataOut); // R1
    end
  end

  AST_START_ON_RST_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> $past(rstFall)); // R2

  AST_HOLD_WITHOUT_SCL_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && $past(dataOe) && !$past(sclFall)) |-> $stable(dataOut)); // R3

  AST_DESELECT_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    csLevel |=> !dataOe); // R7

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> !dataOut); // R8
endmodule

bind atr_shifter atr_shifter_chk u_chk (
  .clk(clk),
  .rstN(rstN),
  .dataOut(dataOut),
  .dataOe(dataOe),
  .csLevel(csLvl),
  .rstFall(rstFallEv),
  .sclFall(sclFallEv)
);

// File: tb/test_atr_shifter.sv
module test_atr_shifter;
  localparam logic [31:0] PAT = 32'hA5C3_1E97;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csPin = 1'b1;
  logic rstPin = 1'b0;
  logic sclPin = 1'b0;
  logic wrBusy = 1'b0;
  logic dataOut, dataOe;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  atr_shifter #(.ATR_BITS(32), .ATR_PATTERN(PAT), .SYNC_STAGES(2)) i_atr_shifter (
    .clk(clk), .rstN(rstN), .csPin(csPin), .rstPin(rstPin), .sclPin(sclPin),
    .wrBusy(wrBusy), .dataOut(dataOut), .dataOe(dataOe)
  );

  function automatic logic expBit(int idx);
    return PAT[idx];
  endfunction

  task automatic check(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic rstPulse();
    rstPin = 1'b1;
    repeat ($urandom_range(4, 8)) @(negedge clk);
    rstPin = 1'b0;
    settle();
  endtask

  // One serial clock period; checks that the rising half keeps bit curIdx.
  task automatic sclPeriod(int curIdx, bit inStream);
    sclPin = 1'b1;
    settle();
    repeat ($urandom_range(0, 3)) @(negedge clk);
    if (inStream) check("R3 rising edge holds bit", dataOut, expBit(curIdx));
    sclPin = 1'b0;
    settle();
    repeat ($urandom_range(0, 3)) @(negedge clk);
  endtask

  task automatic startAndCheck(string tag);
    rstPulse();
    check({tag, " oe"}, dataOe, 1'b1);
    check({tag, " bit0"}, dataOut, expBit(0));
  endtask

  task automatic advance(int fromIdx, int toIdx);
    for (int i = fromIdx; i < toIdx; i++) begin
      sclPeriod(i, 1'b1);
      check("R3 next bit lsb first", dataOut, expBit(i + 1));
      check("R3 oe held", dataOe, 1'b1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 oe in reset", dataOe, 1'b0);
    check("R1 data in reset", dataOut, 1'b0);
    rstN = 1'b1;
    settle();
    check("R8 idle data low", dataOut, 1'b0);

    // Full stream
    csPin = 1'b0;
    settle();
    startAndCheck("R2 start");
    advance(0, 31);
    sclPeriod(31, 1'b1);
    check("R4 oe off after last bit", dataOe, 1'b0);
    check("R8 data low after end", dataOut, 1'b0);
    sclPeriod(0, 1'b0);
    sclPeriod(0, 1'b0);
    check("R4 stays off", dataOe, 1'b0);

    // Busy blocks start
    wrBusy = 1'b1;
    rstPulse();
    wrBusy = 1'b0;
    check("R5 busy blocks start", dataOe, 1'b0);
    sclPeriod(0, 1'b0);
    check("R5 still off", dataOe, 1'b0);

    // Deselected at reset rise
    csPin = 1'b1;
    settle();
    rstPulse();
    csPin = 1'b0;
    settle();
    check("R6 deselected blocks start", dataOe, 1'b0);
    check("R8 data low when deselected", dataOut, 1'b0);

    // Serial clock in the armed window
    rstPin = 1'b1;
    settle();
    sclPeriod(0, 1'b0);
    sclPeriod(0, 1'b0);
    check("R10 no output while armed", dataOe, 1'b0);
    rstPin = 1'b0;
    settle();
    check("R10 first bit is bit0", dataOut, expBit(0));
    check("R10 oe on", dataOe, 1'b1);
    advance(0, 3);

    // Restart mid-stream
    rstPin = 1'b1;
    settle();
    check("R9 off while reset high", dataOe, 1'b0);
    rstPin = 1'b0;
    settle();
    check("R9 restart oe", dataOe, 1'b1);
    check("R9 restart bit0", dataOut, expBit(0));
    advance(0, 2);

    // Deselect while armed
    csPin = 1'b1;
    settle();
    csPin = 1'b0;
    settle();
    rstPin = 1'b1;
    settle();
    csPin = 1'b1;
    settle();
    rstPin = 1'b0;
    settle();
    check("R7 armed abort", dataOe, 1'b0);
    csPin = 1'b0;
    settle();
    check("R7 armed abort stays off", dataOe, 1'b0);

    // Random abort positions
    for (int n = 0; n < 8; n++) begin
      int stopAt;
      stopAt = $urandom_range(0, 31);
      startAndCheck("R2 random start");
      advance(0, stopAt);
      csPin = 1'b1;
      settle();
      check("R7 deselect aborts", dataOe, 1'b0);
      check("R8 data low after abort", dataOut, 1'b0);
      csPin = 1'b0;
      settle();
      sclPeriod(0, 1'b0);
      check("R7 no resume after reselect", dataOe, 1'b0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule